// File: doc/BRIEF.md
# Addressed Command Packet Receiver

This block sits inside every slave controller attached to a shared serial command bus. A UART in front of it delivers received bytes as an 8-bit value with a one-cycle valid strobe. The receiver frames each command packet from a 2-bit length code in the first header byte and checks the 16-bit checksum that follows the header whenever the packet carries data. It keeps only packets addressed to this slave or sent to all slaves.

For each packet it keeps, it presents the decoded header fields and up to four data bytes, together with a single-cycle packet-valid pulse. A packet that is addressed here but fails its checksum is dropped and reported with a single-cycle error pulse. Packets for other slaves are counted through byte by byte so that framing stays aligned, but they produce nothing. A reserved length code, or a silence on the line longer than a parameterised number of clock cycles in the middle of a packet, sends the receiver back to waiting for a first header byte.

Top module: `cmd_pkt_rx`

## Requirements
- R1: The length code in bits 7:6 of header byte 1 sets the packet size: 00 means 2 bytes and no data, 01 means 6 bytes with 2 data bytes, 10 means 8 bytes with 4 data bytes. For data packets, the bytes arrive as header 1, header 2, checksum high byte, checksum low byte, then the data bytes. `pkt_len` reports the data byte count (0, 2 or 4).
- R2: On acceptance, `pkt_hw_sel` equals header 1 bits 5:4, `pkt_exp` equals header 2 bit 6 and `pkt_cmd` equals header 2 bits 5:0. Data byte k (counted from 0 in arrival order) appears on `pkt_data[8k+7:8k]`, and data byte positions the packet does not carry read zero.
- R3: For a packet with data, `pkt_rd` is header 2 bit 7 and `pkt_wr` is its inverse. For a packet with length code 00, both are 0.
- R4: A packet is accepted when the address in header 1 bits 3:0 equals `own_addr`, or equals 15 (broadcast). `pkt_bcast` is 1 exactly when the accepted packet used address 15.
- R5: A packet for another address raises neither `pkt_valid` nor `csum_err`. Its bytes are still counted, so the byte that follows it is taken as a new header 1.
- R6: The checksum is the sum, modulo 2^16, of both header bytes and all data bytes. If it matches the received value, the packet is accepted. If it does not match, `csum_err` pulses for one cycle, `pkt_valid` stays low, and the previously presented fields are unchanged.
- R7: A header 1 with length code 11 is dropped, and the next byte is taken as a new header 1.
- R8: In an unfinished packet, byte strobes up to TIMEOUT_CYC clock edges apart are accepted. If TIMEOUT_CYC consecutive clock edges pass without a strobe, the receiver returns to waiting for header 1.
- R9: `pkt_valid` (or `csum_err`) is a one-cycle pulse, set by the clock edge that samples the final byte of the packet. The output fields keep their values until the next accepted packet.
- R10: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe marking a received byte |
| rx_byte | input | 8 | Received byte |
| own_addr | input | 4 | Address of this slave |
| pkt_valid | output | 1 | One-cycle pulse: an accepted packet is presented |
| pkt_hw_sel | output | 2 | Hardware-select bits |
| pkt_rd | output | 1 | Read request |
| pkt_wr | output | 1 | Write request |
| pkt_exp | output | 1 | Expansion bit |
| pkt_cmd | output | 6 | Command code |
| pkt_len | output | 3 | Number of valid data bytes |
| pkt_data | output | 32 | Data bytes, first byte in bits 7:0 |
| pkt_bcast | output | 1 | Accepted packet was a broadcast |
| csum_err | output | 1 | One-cycle pulse: checksum mismatch on an addressed packet |

## Verification
Every result is registered once. `pkt_valid`, `csum_err` and the new field values become visible just after the rising edge that samples the last byte of the packet. The bench drives each byte at a falling edge and samples `pkt_valid` at the next falling edge, which is exactly that cycle. Pulse counts are read one falling edge later, so they never race the monitor that records them. The timeout is probed with strobes exactly TIMEOUT_CYC edges apart, which must be accepted, and with one extra idle edge, which must abandon the packet.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;

  typedef enum logic [2:0] {
    S_HDR1,
    S_HDR2,
    S_CSH,
    S_CSL,
    S_DATA
  } rx_state_e;

  localparam logic [3:0] BCAST_ADDR = 4'hF;
  localparam logic [1:0] CODE_NONE  = 2'b00;
  localparam logic [1:0] CODE_RSVD  = 2'b11;
  localparam int         MAX_DATA   = 4;

  function automatic logic [2:0] data_count(input logic [1:0] code);
    case (code)
      2'b01:   data_count = 3'd2;
      2'b10:   data_count = 3'd4;
      default: data_count = 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/cmdrx_gap_timer.sv
module cmdrx_gap_timer #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic busy,
  input  logic byte_seen,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !busy || byte_seen) begin
      cnt_q <= '0;
    end else if (cnt_q != LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire = busy && !byte_seen && (cnt_q == LAST);

  // R8: the idle counter never passes the timeout limit
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(TIMEOUT_CYC));

  // R8: an expiry returns the receiver to header wait on the next cycle
  a_r8_expire_idle: assert property (@(posedge clk) disable iff (rst)
    expire |=> !busy);

endmodule

// File: rtl/cmdrx_sum.sv
module cmdrx_sum #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         add,
  input  logic [7:0]   din,
  output logic [W-1:0] sum_q,
  output logic [W-1:0] sum_plus
);
  assign sum_plus = sum_q + W'(din);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q <= '0;
    end else if (load) begin
      sum_q <= W'(din);
    end else if (add) begin
      sum_q <= sum_plus;
    end
  end

endmodule

// File: rtl/cmdrx_data_buf.sv
module cmdrx_data_buf #(
  parameter int NBYTES = 4,
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clear,
  input  logic                wr,
  input  logic [IW-1:0]       idx,
  input  logic [7:0]          din,
  output logic [NBYTES*8-1:0] view
);

  for (genvar k = 0; k < NBYTES; k++) begin : g_slot
    logic [7:0] slot_q;
    logic       hit;

    assign hit = wr && (idx == IW'(k));

    always_ff @(posedge clk) begin
      if (rst || clear) begin
        slot_q <= '0;
      end else if (hit) begin
        slot_q <= din;
      end
    end

    assign view[k*8 +: 8] = hit ? din : slot_q;
  end

endmodule

// File: rtl/cmd_pkt_rx.sv
module cmd_pkt_rx
  import cmdrx_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic [3:0]  own_addr,
  output logic        pkt_valid,
  output logic [1:0]  pkt_hw_sel,
  output logic        pkt_rd,
  output logic        pkt_wr,
  output logic        pkt_exp,
  output logic [5:0]  pkt_cmd,
  output logic [2:0]  pkt_len,
  output logic [31:0] pkt_data,
  output logic        pkt_bcast,
  output logic        csum_err
);
  localparam int IW = $clog2(MAX_DATA);
  localparam int DW = MAX_DATA * 8;

  rx_state_e   st_q;
  logic [1:0]  code_q;
  logic [1:0]  hw_q;
  logic [7:0]  hdr2_q;
  logic [15:0] csum_q;
  logic [IW-1:0] didx_q;
  logic        match_q;
  logic        bcast_q;

  logic        expire;
  logic        busy;
  logic [15:0] sum_q;
  logic [15:0] sum_plus;
  logic [DW-1:0] buf_view;
  logic [2:0]  ndata;
  logic [7:0]  hdr2_now;
  logic        take_hdr1;
  logic        done_nodata;
  logic        last_data;
  logic        sum_ok;
  logic        accept;

  assign busy        = (st_q != S_HDR1);
  assign take_hdr1   = rx_valid && (st_q == S_HDR1);
  assign ndata       = data_count(code_q);
  assign hdr2_now    = (st_q == S_HDR2) ? rx_byte : hdr2_q;
  assign done_nodata = rx_valid && (st_q == S_HDR2) && (code_q == CODE_NONE);
  assign last_data   = rx_valid && (st_q == S_DATA) && ((3'(didx_q) + 3'd1) == ndata);
  assign sum_ok      = (sum_plus == csum_q);
  assign accept      = match_q && (done_nodata || (last_data && sum_ok));

  cmdrx_gap_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_gap (
    .clk       (clk),
    .rst       (rst),
    .busy      (busy),
    .byte_seen (rx_valid),
    .expire    (expire)
  );

  cmdrx_sum #(.W(16)) i_sum (
    .clk      (clk),
    .rst      (rst),
    .load     (take_hdr1),
    .add      (rx_valid && ((st_q == S_HDR2) || (st_q == S_DATA))),
    .din      (rx_byte),
    .sum_q    (sum_q),
    .sum_plus (sum_plus)
  );

  cmdrx_data_buf #(.NBYTES(MAX_DATA)) i_buf (
    .clk   (clk),
    .rst   (rst),
    .clear (take_hdr1),
    .wr    (rx_valid && (st_q == S_DATA)),
    .idx   (didx_q),
    .din   (rx_byte),
    .view  (buf_view)
  );

  // Framing state machine
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= S_HDR1;
      code_q  <= '0;
      hw_q    <= '0;
      hdr2_q  <= '0;
      csum_q  <= '0;
      didx_q  <= '0;
      match_q <= 1'b0;
      bcast_q <= 1'b0;
    end else if (rx_valid) begin
      case (st_q)
        S_HDR1: begin
          if (rx_byte[7:6] != CODE_RSVD) begin
            code_q  <= rx_byte[7:6];
            hw_q    <= rx_byte[5:4];
            match_q <= (rx_byte[3:0] == own_addr) || (rx_byte[3:0] == BCAST_ADDR);
            bcast_q <= (rx_byte[3:0] == BCAST_ADDR);
            st_q    <= S_HDR2;
          end
        end
        S_HDR2: begin
          hdr2_q <= rx_byte;
          st_q   <= (code_q == CODE_NONE) ? S_HDR1 : S_CSH;
        end
        S_CSH: begin
          csum_q[15:8] <= rx_byte;
          st_q         <= S_CSL;
        end
        S_CSL: begin
          csum_q[7:0] <= rx_byte;
          didx_q      <= '0;
          st_q        <= S_DATA;
        end
        S_DATA: begin
          if (last_data) begin
            st_q <= S_HDR1;
          end else begin
            didx_q <= didx_q + 1'b1;
          end
        end
        default: st_q <= S_HDR1;
      endcase
    end else if (expire) begin
      st_q <= S_HDR1;
    end
  end

  // Registered result outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_valid  <= 1'b0;
      csum_err   <= 1'b0;
      pkt_hw_sel <= '0;
      pkt_rd     <= 1'b0;
      pkt_wr     <= 1'b0;
      pkt_exp    <= 1'b0;
      pkt_cmd    <= '0;
      pkt_len    <= '0;
      pkt_data   <= '0;
      pkt_bcast  <= 1'b0;
    end else begin
      pkt_valid <= accept;
      csum_err  <= match_q && last_data && !sum_ok;
      if (accept) begin
        pkt_hw_sel <= hw_q;
        pkt_rd     <= (code_q != CODE_NONE) && hdr2_now[7];
        pkt_wr     <= (code_q != CODE_NONE) && !hdr2_now[7];
        pkt_exp    <= hdr2_now[6];
        pkt_cmd    <= hdr2_now[5:0];
        pkt_len    <= ndata;
        pkt_data   <= buf_view;
        pkt_bcast  <= bcast_q;
      end
    end
  end

  // R9: packet-valid lasts one cycle
  a_r9_valid_pulse: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> !pkt_valid);

  // R9: a result only follows a sampled byte
  a_r9_after_byte: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid || csum_err) |-> $past(rx_valid));

  // R6: error pulse is single-cycle and never coincides with acceptance
  a_r6_err_pulse: assert property (@(posedge clk) disable iff (rst)
    csum_err |=> !csum_err);
  a_r6_err_excl: assert property (@(posedge clk) disable iff (rst)
    !(pkt_valid && csum_err));

  // R3: read and write never both set; no-data packets set neither
  a_r3_rdwr_excl: assert property (@(posedge clk) disable iff (rst)
    !(pkt_rd && pkt_wr));
  a_r3_nodata: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_len == 3'd0) |-> (!pkt_rd && !pkt_wr));

  // R1: only legal data counts are reported
  a_r1_len_legal: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |-> (pkt_len == 3'd0 || pkt_len == 3'd2 || pkt_len == 3'd4));

  // R9: fields hold between accepted packets
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!pkt_valid && !$past(rst)) |-> $stable(pkt_data));

endmodule

// File: tb/test_cmd_pkt_rx.sv
module test_cmd_pkt_rx;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 40;
  localparam logic [3:0] OWN = 4'h5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        pkt_valid, pkt_rd, pkt_wr, pkt_exp, pkt_bcast, csum_err;
  logic [1:0]  pkt_hw_sel;
  logic [5:0]  pkt_cmd;
  logic [2:0]  pkt_len;
  logic [31:0] pkt_data;

  int checks = 0;
  int errors = 0;
  int vcnt = 0;
  int ecnt = 0;
  int dbl = 0;
  logic prev_v = 1'b0;
  logic v_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_pkt_rx #(.TIMEOUT_CYC(TMO)) i_cmd_pkt_rx (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_byte(rx_byte), .own_addr(OWN),
    .pkt_valid(pkt_valid), .pkt_hw_sel(pkt_hw_sel), .pkt_rd(pkt_rd), .pkt_wr(pkt_wr),
    .pkt_exp(pkt_exp), .pkt_cmd(pkt_cmd), .pkt_len(pkt_len), .pkt_data(pkt_data),
    .pkt_bcast(pkt_bcast), .csum_err(csum_err)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (pkt_valid) vcnt++;
      if (csum_err) ecnt++;
      if (pkt_valid && prev_v) dbl++;
      prev_v = pkt_valid;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Caller is at a falling edge; returns at a falling edge
  task automatic send_byte(input logic [7:0] b, input int idle);
    rx_valid = 1'b1;
    rx_byte  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    v_end = pkt_valid;
    repeat (idle) @(negedge clk);
  endtask

  function automatic logic [15:0] ck(input logic [7:0] h1, input logic [7:0] h2,
                                     input logic [31:0] d, input int n);
    logic [15:0] s;
    s = 16'(h1) + 16'(h2);
    for (int i = 0; i < n; i++) s = s + 16'(d[8*i +: 8]);
    return s;
  endfunction

  task automatic send_pkt(input logic [7:0] h1, input logic [7:0] h2, input logic [31:0] d,
                          input logic bad, input int gap);
    int n;
    logic [15:0] s;
    n = (h1[7:6] == 2'b01) ? 2 : (h1[7:6] == 2'b10) ? 4 : 0;
    s = ck(h1, h2, d, n) ^ (bad ? 16'h0001 : 16'h0000);
    send_byte(h1, gap);
    if (n == 0) begin
      send_byte(h2, 0);
    end else begin
      send_byte(h2, gap);
      send_byte(s[15:8], gap);
      send_byte(s[7:0], gap);
      for (int i = 0; i < n; i++) send_byte(d[8*i +: 8], (i == n-1) ? 0 : gap);
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk(pkt_valid == 0 && csum_err == 0, "R10 reset pulses", {pkt_valid, csum_err}, 0);
    chk(pkt_data == 0 && pkt_cmd == 0 && pkt_len == 0 && pkt_hw_sel == 0 &&
        !pkt_rd && !pkt_wr && !pkt_exp && !pkt_bcast, "R10 reset fields", pkt_data, 0);
  endtask

  task automatic t_nodata();
    int v0 = vcnt;
    send_pkt(8'h25, 8'hAA, 32'h0, 1'b0, 0);
    chk(v_end == 1'b1, "R9 pulse after last byte", v_end, 1);
    chk(vcnt == v0 + 1, "R1 two-byte packet accepted", vcnt, v0 + 1);
    chk(!pkt_rd && !pkt_wr, "R3 no-data neither read nor write", {pkt_rd, pkt_wr}, 0);
    chk(pkt_cmd == 6'h2A && pkt_hw_sel == 2'd2 && pkt_len == 0, "R2 fields code 00",
        {pkt_hw_sel, pkt_len, pkt_cmd}, {2'd2, 3'd0, 6'h2A});
  endtask

  task automatic t_read2();
    int v0 = vcnt;
    send_pkt(8'h55, 8'hC7, 32'h0000BEEF, 1'b0, 1);
    chk(v_end == 1'b1 && vcnt == v0 + 1, "R1 six-byte packet accepted", vcnt, v0 + 1);
    chk(pkt_rd && !pkt_wr && pkt_exp, "R3 read flag", {pkt_rd, pkt_wr, pkt_exp}, 3'b101);
    chk(pkt_data == 32'h0000BEEF && pkt_len == 3'd2, "R2 two data bytes", pkt_data, 32'h0000BEEF);
    chk(pkt_cmd == 6'h07 && pkt_hw_sel == 2'd1 && !pkt_bcast, "R2 header fields",
        {pkt_bcast, pkt_hw_sel, pkt_cmd}, {1'b0, 2'd1, 6'h07});
  endtask

  task automatic t_bcast4();
    int v0 = vcnt;
    send_pkt(8'hBF, 8'h15, 32'h11223344, 1'b0, 0);
    chk(vcnt == v0 + 1 && pkt_bcast, "R4 broadcast accepted", pkt_bcast, 1);
    chk(pkt_wr && !pkt_rd && pkt_len == 3'd4, "R3 write flag", {pkt_rd, pkt_wr}, 2'b01);
    chk(pkt_data == 32'h11223344, "R1 four data bytes", pkt_data, 32'h11223344);
  endtask

  task automatic t_badcs();
    int v0 = vcnt;
    int e0 = ecnt;
    send_pkt(8'h95, 8'h3F, 32'hA5A5A5A5, 1'b1, 0);
    chk(ecnt == e0 + 1, "R6 checksum error pulse", ecnt, e0 + 1);
    chk(vcnt == v0, "R6 bad packet not accepted", vcnt, v0);
    chk(pkt_data == 32'h11223344 && pkt_cmd == 6'h15, "R9 fields held after error",
        pkt_data, 32'h11223344);
  endtask

  task automatic t_foreign();
    int v0 = vcnt;
    int e0 = ecnt;
    send_pkt(8'h83, 8'h01, 32'h09050905, 1'b0, 0);
    chk(vcnt == v0 && ecnt == e0, "R5 foreign packet ignored", vcnt, v0);
    send_pkt(8'h95, 8'h01, 32'h0, 1'b1, 0);
    chk(ecnt == e0 + 1, "R6 error for addressed packet", ecnt, e0 + 1);
    send_pkt(8'h83, 8'h01, 32'h09050905, 1'b1, 0);
    chk(ecnt == e0 + 1, "R5 no error for foreign packet", ecnt, e0 + 1);
    send_pkt(8'h05, 8'h33, 32'h0, 1'b0, 0);
    chk(vcnt == v0 + 1 && pkt_cmd == 6'h33, "R5 framing kept after foreign", pkt_cmd, 6'h33);
  endtask

  task automatic t_abort();
    int v0 = vcnt;
    send_byte(8'hC5, 0);
    send_pkt(8'h05, 8'h21, 32'h0, 1'b0, 0);
    chk(vcnt == v0 + 1 && pkt_cmd == 6'h21, "R7 reserved code dropped", pkt_cmd, 6'h21);
  endtask

  task automatic t_gap_ok();
    int v0 = vcnt;
    send_pkt(8'h55, 8'h0C, 32'h00007E81, 1'b0, TMO - 1);
    chk(vcnt == v0 + 1 && pkt_data == 32'h00007E81, "R8 max gap accepted", pkt_data, 32'h00007E81);
  endtask

  task automatic t_timeout();
    int v0 = vcnt;
    send_byte(8'h55, TMO);
    send_pkt(8'h05, 8'h3C, 32'h0, 1'b0, 0);
    chk(vcnt == v0 + 1 && pkt_cmd == 6'h3C, "R8 timeout resyncs", pkt_cmd, 6'h3C);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_nodata();
    t_read2();
    t_bcast4();
    t_badcs();
    t_foreign();
    t_abort();
    t_gap_ok();
    t_timeout();
    @(negedge clk);
    chk(dbl == 0, "R9 single-cycle pulse", dbl, 0);
    summary();
  end

endmodule